// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps a small number of recent virtual-page to physical-page translations close to the address path, so that most memory accesses obtain their physical page number without reading the page table in memory. A requester presents an 8-bit virtual page number (VPN). One cycle later the block answers with hit or miss and, on a hit, the 6-bit physical page number (PPN) and the 3 permission bits stored with that translation. The block treats the permission bits as opaque and does not interpret them.

On a miss the requester fetches the page table entry with one extra memory access, through a walker outside this block, and writes the result back through the fill port. An invalidate-all input discards every cached translation at once, for example when the address space changes. The 16 entries are arranged as 4 sets of 4 ways. The low bits of the VPN select the set and the remaining VPN bits are kept as the tag.

Top module: `xlat_cache`

## Requirements
- R1: The set index is `vpn[1:0]` and the tag is `vpn[7:2]`. Each set holds 4 ways, so 16 translations with distinct VPNs, 4 in every set, can all be resident at once and each returns its own PPN and permission bits.
- R2: A lookup raises `rsp_valid` exactly one cycle after `lk_req`, and `rsp_valid` is low in any cycle that does not follow a request. On a miss, `rsp_hit`, `rsp_ppn` and `rsp_perm` are all 0. Without a response, `rsp_hit` is 0.
- R3: A hit needs a valid way in the indexed set whose stored tag equals the VPN tag. A VPN that matches a cached entry in set bits only, or in tag bits only, misses.
- R4: After a fill, a lookup of the same VPN hits and returns the filled PPN and permission bits. This holds already for a lookup issued in the cycle after the fill.
- R5: A fill into a set that has an invalid way writes that way and evicts no valid entry.
- R6: When all 4 ways of the target set are valid, a fill evicts the way named by that set's round-robin pointer. The pointer starts at way 0 after reset and advances by one, wrapping from way 3 to way 0, only on such an eviction. Each set has its own pointer.
- R7: A fill whose tag matches a valid way in the target set overwrites that way's PPN and permissions. It creates no second copy and does not advance the round-robin pointer.
- R8: Invalidate-all (`flush_all`) clears every entry in one cycle, so every lookup issued after it misses until new fills arrive.
- R9: When `flush_all` and `fill_en` are high in the same cycle, the flush wins and the fill is dropped.
- R10: A lookup issued in the same cycle as a fill sees the contents from before that fill.
- R11: After reset, `rsp_valid` and `rsp_hit` are 0 and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 8 | Virtual page number to translate |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 8 | VPN of the translation being written |
| fill_ppn | input | 6 | PPN of the translation being written |
| fill_perm | input | 3 | Permission bits stored with the translation |
| flush_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response present, one cycle after lk_req |
| rsp_hit | output | 1 | Translation found |
| rsp_ppn | output | 6 | Physical page number, 0 on a miss |
| rsp_perm | output | 3 | Permission bits, 0 on a miss |

## Verification
The bench fills one set past capacity and checks which VPNs survive. A design that picked the wrong victim, or moved the pointer of the wrong set, loses a translation other than the oldest one. It refills a resident tag and then adds two more entries. A design that made a duplicate would later evict a different way and keep a VPN that should have gone. It also drives a flush together with a fill, and a lookup together with a fill. A design with the wrong priority would keep the dropped entry. A design that bypassed the fill data into the lookup would report a hit one cycle early.

// File: rtl/xlat_pkg.sv
// Shared geometry defaults for the page translation cache.
// Assumes power-of-two way and set counts.
package xlat_pkg;
    localparam int XL_VPN_W  = 8;
    localparam int XL_PPN_W  = 6;
    localparam int XL_PERM_W = 3;
    localparam int XL_WAYS   = 4;
    localparam int XL_SETS   = 4;
endpackage

// File: rtl/xlat_pick.sv
// Chooses the way a fill writes within one set.
// Priority: a valid way with the same tag, then the lowest invalid way,
// then the round-robin pointer. evict is high only in the last case.
// Assumes at most one bit of match is set.
module xlat_pick #(
    parameter int WAYS  = 4,
    parameter int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  match,
    input  logic [IDX_W-1:0] rr,
    output logic [IDX_W-1:0] way,
    output logic             evict
);
    logic found;

    // Pick the target way by the priority above.
    always_comb begin
        way   = rr;
        evict = 1'b1;
        found = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (!found && match[i]) begin
                way   = IDX_W'(i);
                evict = 1'b0;
                found = 1'b1;
            end
        end
        for (int i = 0; i < WAYS; i++) begin
            if (!found && !valid[i]) begin
                way   = IDX_W'(i);
                evict = 1'b0;
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlat_set.sv
// One set of the translation cache: WAYS entries, each holding a valid bit,
// a tag, a PPN and permission bits. Read is combinational. Writes happen
// at the clock edge. Assumes the parent never raises wr_en and flush together.
module xlat_set #(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 6,
    parameter int PPN_W  = 6,
    parameter int PERM_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [PPN_W-1:0]  rd_ppn,
    output logic [PERM_W-1:0] rd_perm
);
    localparam int IDX_W = $clog2(WAYS);

    logic [WAYS-1:0]   vld;
    logic [TAG_W-1:0]  tags  [WAYS];
    logic [PPN_W-1:0]  ppns  [WAYS];
    logic [PERM_W-1:0] perms [WAYS];
    logic [WAYS-1:0]   rd_match;
    logic [WAYS-1:0]   wr_match;
    logic [IDX_W-1:0]  rr_ptr;
    logic [IDX_W-1:0]  tgt_way;
    logic              tgt_evict;

    // Compare the read and write tags against every way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign rd_match[w] = vld[w] && (tags[w] == rd_tag);
        assign wr_match[w] = vld[w] && (tags[w] == wr_tag);
    end

    // Merge the matching way onto the read outputs (all zero on a miss).
    always_comb begin
        rd_hit  = |rd_match;
        rd_ppn  = '0;
        rd_perm = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (rd_match[i]) begin
                rd_ppn  = rd_ppn  | ppns[i];
                rd_perm = rd_perm | perms[i];
            end
        end
    end

    xlat_pick #(.WAYS(WAYS), .IDX_W(IDX_W)) u_pick (
        .valid (vld),
        .match (wr_match),
        .rr    (rr_ptr),
        .way   (tgt_way),
        .evict (tgt_evict)
    );

    // Advance the replacement pointer only when a valid way is evicted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (wr_en && tgt_evict)
            rr_ptr <= rr_ptr + 1'b1;
    end

    // Maintain the valid bits: clear all on flush, set the written way.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            vld <= '0;
        else if (wr_en)
            vld[tgt_way] <= 1'b1;
    end

    // Store the tag and the entry contents of the written way.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[tgt_way]  <= wr_tag;
            ppns[tgt_way]  <= wr_ppn;
            perms[tgt_way] <= wr_perm;
        end
    end
endmodule

// File: rtl/xlat_cache.sv
// Set-associative page translation cache (top level).
// The low VPN bits pick the set and the rest form the tag. A lookup is
// resolved combinationally and answered through registers one cycle later.
// A fill in the same cycle as a lookup is not visible to that lookup.
// Flush overrides a fill in the same cycle.
module xlat_cache #(
    parameter int VPN_W  = xlat_pkg::XL_VPN_W,
    parameter int PPN_W  = xlat_pkg::XL_PPN_W,
    parameter int PERM_W = xlat_pkg::XL_PERM_W,
    parameter int WAYS   = xlat_pkg::XL_WAYS,
    parameter int SETS   = xlat_pkg::XL_SETS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              flush_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [PERM_W-1:0] rsp_perm
);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - SET_W;

    logic [SET_W-1:0]  lk_set;
    logic [SET_W-1:0]  fill_set;
    logic              fill_go;
    logic              set_hit  [SETS];
    logic [PPN_W-1:0]  set_ppn  [SETS];
    logic [PERM_W-1:0] set_perm [SETS];

    assign lk_set   = lk_vpn[SET_W-1:0];
    assign fill_set = fill_vpn[SET_W-1:0];
    assign fill_go  = fill_en && !flush_all;

    // One storage set per index value.
    for (genvar s = 0; s < SETS; s++) begin : g_set
        xlat_set #(
            .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
        ) u_set (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush_all),
            .wr_en   (fill_go && (fill_set == SET_W'(s))),
            .wr_tag  (fill_vpn[VPN_W-1:SET_W]),
            .wr_ppn  (fill_ppn),
            .wr_perm (fill_perm),
            .rd_tag  (lk_vpn[VPN_W-1:SET_W]),
            .rd_hit  (set_hit[s]),
            .rd_ppn  (set_ppn[s]),
            .rd_perm (set_perm[s])
        );
    end

    // Register the selected set's result as the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && set_hit[lk_set];
            rsp_ppn   <= (lk_req && set_hit[lk_set]) ? set_ppn[lk_set]  : '0;
            rsp_perm  <= (lk_req && set_hit[lk_set]) ? set_perm[lk_set] : '0;
        end
    end
endmodule

// File: rtl/xlat_cache_chk.sv
// Protocol checks on the translation cache ports. Bound to every instance.
module xlat_cache_chk #(
    parameter int VPN_W  = 8,
    parameter int PPN_W  = 6,
    parameter int PERM_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_req,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic              fill_en,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [PPN_W-1:0]  fill_ppn,
    input logic [PERM_W-1:0] fill_perm,
    input logic              flush_all,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [PPN_W-1:0]  rsp_ppn,
    input logic [PERM_W-1:0] rsp_perm
);
    a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_perm == '0));

    a_r2_no_hit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit);

    a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all) ##1 (lk_req && lk_vpn == $past(fill_vpn))
        |=> (rsp_hit && rsp_ppn == $past(fill_ppn, 2)
             && rsp_perm == $past(fill_perm, 2)));

    a_r8_flush_misses: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all ##1 (lk_req && !fill_en) |=> !rsp_hit);
endmodule

bind xlat_cache xlat_cache_chk #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
) u_chk (.*);

// File: tb/xlat_cache_test.sv
// Directed bench for the translation cache. Inputs change on falling edges.
// A response is sampled at the falling edge after the request's rising edge.
module xlat_cache_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lk_req = 1'b0;
    logic [7:0] lk_vpn = '0;
    logic       fill_en = 1'b0;
    logic [7:0] fill_vpn = '0;
    logic [5:0] fill_ppn = '0;
    logic [2:0] fill_perm = '0;
    logic       flush_all = 1'b0;
    logic       rsp_valid, rsp_hit;
    logic [5:0] rsp_ppn;
    logic [2:0] rsp_perm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xlat_cache uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] v, input logic [5:0] p, input logic [2:0] pm);
        fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_perm = pm;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic flush();
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
    endtask

    // Single lookup; checks valid, hit, ppn and perm.
    task automatic look(input string req, input logic [7:0] v, input bit hit,
                        input int p, input int pm);
        lk_req = 1'b1; lk_vpn = v;
        @(negedge clk);
        lk_req = 1'b0;
        chk({req, " valid"}, int'(rsp_valid), 1);
        chk({req, " hit"},   int'(rsp_hit), int'(hit));
        chk({req, " ppn"},   int'(rsp_ppn), hit ? p : 0);
        chk({req, " perm"},  int'(rsp_perm), hit ? pm : 0);
    endtask

    function automatic logic [7:0] va(input int tag, input int set);
        return 8'((tag << 2) | set);
    endfunction

    task automatic t_reset();
        chk("R11 valid after reset", int'(rsp_valid), 0);
        chk("R11 hit after reset", int'(rsp_hit), 0);
        look("R11 miss after reset", va(5, 1), 1'b0, 0, 0);
        @(negedge clk);
        chk("R2 valid drops without request", int'(rsp_valid), 0);
    endtask

    task automatic t_full_capacity();
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 4; t++)
                fill(va(t * 9 + 1, s), 6'(s * 4 + t + 1), 3'(t + s));
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 4; t++)
                look("R1 R5 all 16 resident", va(t * 9 + 1, s), 1'b1,
                     s * 4 + t + 1, (t + s) & 7);
    endtask

    task automatic t_tag_set_mismatch();
        look("R3 same tag other set", va(1, 0), 1'b1, 1, 0);
        fill(va(40, 2), 6'd50, 3'd1);  // evicts way 0 of set 2 (tag 1)
        look("R3 tag only match, other set", va(40, 3), 1'b0, 0, 0);
        look("R3 set only match, other tag", va(41, 2), 1'b0, 0, 0);
        look("R4 hit after fill", va(40, 2), 1'b1, 50, 1);
    endtask

    task automatic t_flush();
        flush();
        for (int s = 0; s < 4; s++)
            look("R8 miss after flush", va(10, s), 1'b0, 0, 0);
        look("R8 miss previously resident", va(40, 2), 1'b0, 0, 0);
    endtask

    // Set 3 pointer starts at 0; set 2 pointer is already at 1.
    task automatic t_round_robin();
        for (int t = 1; t <= 5; t++) fill(va(t, 3), 6'(t), 3'd2);
        look("R6 oldest evicted set3", va(1, 3), 1'b0, 0, 0);
        for (int t = 2; t <= 5; t++) look("R6 survivors set3", va(t, 3), 1'b1, t, 2);
        fill(va(6, 3), 6'd6, 3'd2);
        look("R6 second victim set3", va(2, 3), 1'b0, 0, 0);
        look("R6 newest resident set3", va(6, 3), 1'b1, 6, 2);
        for (int t = 11; t <= 15; t++) fill(va(t, 2), 6'(t), 3'd4);
        look("R6 per-set pointer set2 victim way1", va(12, 2), 1'b0, 0, 0);
        look("R6 set2 way0 kept", va(11, 2), 1'b1, 11, 4);
        look("R6 set2 newest", va(15, 2), 1'b1, 15, 4);
    endtask

    task automatic t_overwrite();
        flush();
        fill(va(20, 1), 6'd20, 3'd1);
        fill(va(21, 1), 6'd21, 3'd1);
        fill(va(22, 1), 6'd22, 3'd1);
        fill(va(20, 1), 6'd33, 3'd7);
        look("R7 overwrite returns new data", va(20, 1), 1'b1, 33, 7);
        fill(va(23, 1), 6'd23, 3'd1);
        fill(va(24, 1), 6'd24, 3'd1);
        look("R7 no duplicate: way0 evicted", va(20, 1), 1'b0, 0, 0);
        look("R7 way1 kept", va(21, 1), 1'b1, 21, 1);
        look("R7 new entry", va(24, 1), 1'b1, 24, 1);
    endtask

    task automatic t_flush_vs_fill();
        flush_all = 1'b1;
        fill(va(30, 0), 6'd30, 3'd3);
        flush_all = 1'b0;
        look("R9 fill dropped under flush", va(30, 0), 1'b0, 0, 0);
        look("R9 flush still applied", va(21, 1), 1'b0, 0, 0);
    endtask

    task automatic t_same_cycle();
        lk_req = 1'b1; lk_vpn = va(35, 0);
        fill(va(35, 0), 6'd45, 3'd5);
        lk_req = 1'b0;
        chk("R10 same-cycle lookup misses", int'(rsp_hit), 0);
        chk("R10 same-cycle response valid", int'(rsp_valid), 1);
        look("R10 next lookup hits", va(35, 0), 1'b1, 45, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_capacity();
        t_tag_set_mismatch();
        t_flush();
        t_round_robin();
        t_overwrite();
        t_flush_vs_fill();
        t_same_cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule